// File: doc/BRIEF.md
# DMA channel event flag unit

This block gathers the event pulses of a multi-channel DMA engine and keeps them as sticky status flags, one group of flags per channel. Each channel reports three kinds of event: the halfway point of a transfer, the end of a transfer and a transfer error. A one-cycle pulse on any of these inputs sets the matching flag. The flag then stays set until software clears it. Each channel also shows a summary flag, which is set while any of its three event flags is set.

Software sees the flags through a word-wide register port. One address holds a read-only status word. A second address holds a write-only clear word that reads as zero. In the clear word, a 1 in a flag's bit clears that flag. A 1 in a channel's summary bit clears all of that channel's flags at once.

Per-channel enable inputs select which flagged events raise that channel's interrupt line. The interrupt lines are built from the registered flags with no further register, so they follow the flags without added latency.

Top module: `dma_evt_flags`

## Requirements
- R1: After reset, every flag is clear, the status word reads 0x00000000 and every interrupt line is low.
- R2: A one-cycle event pulse on channel c (c counted from 0) sets its flag at the clock edge where the pulse is sampled. The flag stays set after the pulse ends. Status bit positions for channel c are: summary at 4c, transfer-complete at 4c+1, half-transfer at 4c+2, error at 4c+3.
- R3: A channel's summary bit reads 1 exactly when at least one of its complete, half or error flags is set.
- R4: A write to offset 0x04 with a 1 in a flag's bit position clears only that flag. Other flags are unchanged, and bits written as 0 have no effect.
- R5: A write to offset 0x04 with a 1 at a channel's summary position (4c) clears all three flags of that channel.
- R6: When an event pulse and a clear of the same flag occur in the same cycle, the flag ends up set.
- R7: The interrupt line of channel c is high exactly when, for at least one of its three event types, both the flag and that type's enable input are 1. The summary flag has no enable and does not drive the line by itself.
- R8: A read at offset 0x04, or at any address other than 0x00, returns zero.
- R9: A write to the status offset 0x00 changes no flag.
- R10: After a clear write, the interrupt line falls in the cycle that follows the clock edge taking the write. It stays high in the cycle of the write itself.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ht_evt | input | N_CH | Half-transfer event pulses, one per channel |
| tc_evt | input | N_CH | Transfer-complete event pulses, one per channel |
| te_evt | input | N_CH | Transfer-error event pulses, one per channel |
| ht_en | input | N_CH | Half-transfer interrupt enables |
| tc_en | input | N_CH | Transfer-complete interrupt enables |
| te_en | input | N_CH | Transfer-error interrupt enables |
| bus_addr | input | ADDR_W | Byte address of the register access |
| bus_wr | input | 1 | Write strobe, one word per cycle |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data, combinational from the address |
| irq | output | N_CH | Interrupt line per channel |

## Verification
The bench places a clear and a new event for the same flag in one cycle. A design that gave priority to the clear would lose that event. The bench uses the summary-bit clear and checks that it removes exactly one channel's three flags and leaves the neighbouring channels alone. It writes all ones to the status offset, which would erase or corrupt flags if the decode were loose. It checks that the interrupt line stays high during the clear cycle and is low one cycle later, which catches an added register stage or a missing one. Random cycles then mix events, enables and partial clears, and a bench model predicts the status word and interrupt lines for every cycle.

// File: rtl/dma_evt_pkg.sv
package dma_evt_pkg;
   // Field offsets inside one channel's nibble of the status / clear word
   localparam int unsigned FLD_GLB    = 0;
   localparam int unsigned FLD_TC     = 1;
   localparam int unsigned FLD_HT     = 2;
   localparam int unsigned FLD_TE     = 3;
   localparam int unsigned FLD_PER_CH = 4;

   typedef struct packed {
      logic te;
      logic ht;
      logic tc;
   } evt_t;
endpackage

// File: rtl/dma_evt_chan.sv
module dma_evt_chan
   import dma_evt_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  evt_t       evt,
   input  evt_t       en,
   input  evt_t       clr,
   input  logic       clr_all,
   output evt_t       flags,
   output logic [3:0] nibble,
   output logic       irq
);
   evt_t flags_q;
   evt_t flags_d;
   evt_t drop;

   // Clear first, then OR in the new events, so an event in the clear cycle survives
   always_comb begin
      drop    = clr | {3{clr_all}};
      flags_d = evt | (flags_q & ~drop);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) flags_q <= '0;
      else        flags_q <= flags_d;
   end

   always_comb begin
      flags = flags_q;
      nibble[FLD_GLB] = |flags_q;
      nibble[FLD_TC]  = flags_q.tc;
      nibble[FLD_HT]  = flags_q.ht;
      nibble[FLD_TE]  = flags_q.te;
      irq = |(flags_q & en);
   end
endmodule

// File: rtl/dma_evt_regif.sv
module dma_evt_regif #(
   parameter int unsigned ADDR_W     = 8,
   parameter int unsigned DATA_W     = 32,
   parameter int unsigned STATUS_OFS = 0,
   parameter int unsigned CLEAR_OFS  = 4
) (
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_wr,
   input  logic [DATA_W-1:0] bus_wdata,
   input  logic [DATA_W-1:0] status_word,
   output logic [DATA_W-1:0] clr_mask,
   output logic [DATA_W-1:0] bus_rdata
);
   localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(STATUS_OFS);
   localparam logic [ADDR_W-1:0] A_CLR  = ADDR_W'(CLEAR_OFS);

   logic hit_stat;
   logic hit_clr;

   always_comb begin
      hit_stat  = (bus_addr == A_STAT);
      hit_clr   = (bus_addr == A_CLR);
      clr_mask  = (bus_wr && hit_clr) ? bus_wdata : '0;
      // Clear word and unmapped addresses read as zero
      bus_rdata = hit_stat ? status_word : '0;
   end
endmodule

// File: rtl/dma_evt_flags.sv
module dma_evt_flags
   import dma_evt_pkg::*;
#(
   parameter int unsigned N_CH       = 8,
   parameter int unsigned ADDR_W     = 8,
   parameter int unsigned DATA_W     = 32,
   parameter int unsigned STATUS_OFS = 0,
   parameter int unsigned CLEAR_OFS  = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [N_CH-1:0]   ht_evt,
   input  logic [N_CH-1:0]   tc_evt,
   input  logic [N_CH-1:0]   te_evt,
   input  logic [N_CH-1:0]   ht_en,
   input  logic [N_CH-1:0]   tc_en,
   input  logic [N_CH-1:0]   te_en,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_wr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   output logic [N_CH-1:0]   irq
);
   localparam int unsigned USED_W = N_CH * FLD_PER_CH;

   generate
      if (N_CH < 1)
         $error("dma_evt_flags: N_CH must be at least 1");
      if (USED_W > DATA_W)
         $error("dma_evt_flags: N_CH channels do not fit in DATA_W bits");
      if (STATUS_OFS == CLEAR_OFS)
         $error("dma_evt_flags: status and clear offsets collide");
      if ((STATUS_OFS % 4 != 0) || (CLEAR_OFS % 4 != 0))
         $error("dma_evt_flags: offsets must be word aligned");
      if ((STATUS_OFS >= (1 << ADDR_W)) || (CLEAR_OFS >= (1 << ADDR_W)))
         $error("dma_evt_flags: offsets exceed ADDR_W");
   endgenerate

   logic [DATA_W-1:0] status_word;
   logic [DATA_W-1:0] clr_mask;
   logic [USED_W-1:0] status_used;
   logic [N_CH-1:0]   tc_vec;
   logic [N_CH-1:0]   ht_vec;
   logic [N_CH-1:0]   te_vec;

   dma_evt_regif #(
      .ADDR_W    (ADDR_W),
      .DATA_W    (DATA_W),
      .STATUS_OFS(STATUS_OFS),
      .CLEAR_OFS (CLEAR_OFS)
   ) u_regif (
      .bus_addr   (bus_addr),
      .bus_wr     (bus_wr),
      .bus_wdata  (bus_wdata),
      .status_word(status_word),
      .clr_mask   (clr_mask),
      .bus_rdata  (bus_rdata)
   );

   for (genvar c = 0; c < N_CH; c++) begin : g_ch
      localparam int unsigned B = c * FLD_PER_CH;
      evt_t ev, en, cl, fl;

      always_comb begin
         ev = '{te: te_evt[c], ht: ht_evt[c], tc: tc_evt[c]};
         en = '{te: te_en[c],  ht: ht_en[c],  tc: tc_en[c]};
         cl = '{te: clr_mask[B+FLD_TE], ht: clr_mask[B+FLD_HT], tc: clr_mask[B+FLD_TC]};
      end

      dma_evt_chan u_chan (
         .clk    (clk),
         .rst_n  (rst_n),
         .evt    (ev),
         .en     (en),
         .clr    (cl),
         .clr_all(clr_mask[B+FLD_GLB]),
         .flags  (fl),
         .nibble (status_used[B +: FLD_PER_CH]),
         .irq    (irq[c])
      );

      assign tc_vec[c] = fl.tc;
      assign ht_vec[c] = fl.ht;
      assign te_vec[c] = fl.te;
   end

   if (USED_W < DATA_W) begin : g_pad
      assign status_word = {{(DATA_W-USED_W){1'b0}}, status_used};
   end else begin : g_full
      assign status_word = status_used;
   end
endmodule

// File: rtl/dma_evt_flags_chk.sv
module dma_evt_flags_chk #(
   parameter int unsigned N_CH       = 8,
   parameter int unsigned ADDR_W     = 8,
   parameter int unsigned DATA_W     = 32,
   parameter int unsigned STATUS_OFS = 0,
   parameter int unsigned CLEAR_OFS  = 4
) (
   input logic              clk,
   input logic              rst_n,
   input logic [N_CH-1:0]   ht_evt,
   input logic [N_CH-1:0]   tc_evt,
   input logic [N_CH-1:0]   te_evt,
   input logic [N_CH-1:0]   ht_en,
   input logic [N_CH-1:0]   tc_en,
   input logic [N_CH-1:0]   te_en,
   input logic [ADDR_W-1:0] bus_addr,
   input logic              bus_wr,
   input logic [DATA_W-1:0] bus_wdata,
   input logic [DATA_W-1:0] bus_rdata,
   input logic [N_CH-1:0]   irq,
   input logic [N_CH-1:0]   tc_vec,
   input logic [N_CH-1:0]   ht_vec,
   input logic [N_CH-1:0]   te_vec
);
   logic clr_wr;
   assign clr_wr = bus_wr && (bus_addr == ADDR_W'(CLEAR_OFS));

   // R2: a pulse sets its flag at the next edge
   a_r2_set_tc: assert property (@(posedge clk) disable iff (!rst_n)
      (tc_evt != 0) |=> ((tc_vec & $past(tc_evt)) == $past(tc_evt)));
   a_r2_set_ht: assert property (@(posedge clk) disable iff (!rst_n)
      (ht_evt != 0) |=> ((ht_vec & $past(ht_evt)) == $past(ht_evt)));
   a_r2_set_te: assert property (@(posedge clk) disable iff (!rst_n)
      (te_evt != 0) |=> ((te_vec & $past(te_evt)) == $past(te_evt)));

   // R9 / R2: without a clear write, no flag ever falls
   a_r9_no_fall: assert property (@(posedge clk) disable iff (!rst_n)
      !clr_wr |=> (((tc_vec & $past(tc_vec)) == $past(tc_vec)) &&
                   ((ht_vec & $past(ht_vec)) == $past(ht_vec)) &&
                   ((te_vec & $past(te_vec)) == $past(te_vec))));

   // R6: an event beats a clear in the same cycle
   a_r6_evt_wins: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_wr && (tc_evt != 0)) |=> ((tc_vec & $past(tc_evt)) == $past(tc_evt)));

   // R8: clear word reads zero
   a_r8_clr_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_addr == ADDR_W'(CLEAR_OFS)) |-> (bus_rdata == '0));

   // R7: no enables, no interrupts
   a_r7_no_enable: assert property (@(posedge clk) disable iff (!rst_n)
      ((ht_en | tc_en | te_en) == '0) |-> (irq == '0));

   for (genvar c = 0; c < N_CH; c++) begin : g_c
      // R3: summary bit tracks the three flags
      a_r3_summary: assert property (@(posedge clk) disable iff (!rst_n)
         (bus_addr == ADDR_W'(STATUS_OFS)) |->
            (bus_rdata[4*c] == (tc_vec[c] | ht_vec[c] | te_vec[c])));
      // R5: summary clear without new events empties the channel
      a_r5_group_clear: assert property (@(posedge clk) disable iff (!rst_n)
         (clr_wr && bus_wdata[4*c] && !tc_evt[c] && !ht_evt[c] && !te_evt[c]) |=>
            (!tc_vec[c] && !ht_vec[c] && !te_vec[c]));
   end
endmodule

bind dma_evt_flags dma_evt_flags_chk #(
   .N_CH(N_CH), .ADDR_W(ADDR_W), .DATA_W(DATA_W),
   .STATUS_OFS(STATUS_OFS), .CLEAR_OFS(CLEAR_OFS)
) u_chk (
   .clk(clk), .rst_n(rst_n),
   .ht_evt(ht_evt), .tc_evt(tc_evt), .te_evt(te_evt),
   .ht_en(ht_en), .tc_en(tc_en), .te_en(te_en),
   .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
   .bus_rdata(bus_rdata), .irq(irq),
   .tc_vec(tc_vec), .ht_vec(ht_vec), .te_vec(te_vec)
);

// File: tb/tb_dma_evt_flags.sv
module tb_dma_evt_flags;
   localparam int N = 8;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [N-1:0] ht_evt = '0, tc_evt = '0, te_evt = '0;
   logic [N-1:0] ht_en = '0, tc_en = '0, te_en = '0;
   logic [7:0]  bus_addr = '0;
   logic        bus_wr = 1'b0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic [N-1:0] irq;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   logic [N-1:0] m_tc = '0, m_ht = '0, m_te = '0;

   always #10 clk = ~clk;

   dma_evt_flags dut (
      .clk(clk), .rst_n(rst_n),
      .ht_evt(ht_evt), .tc_evt(tc_evt), .te_evt(te_evt),
      .ht_en(ht_en), .tc_en(tc_en), .te_en(te_en),
      .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
      .bus_rdata(bus_rdata), .irq(irq)
   );

   function automatic logic [31:0] exp_status();
      logic [31:0] s = '0;
      for (int c = 0; c < N; c++) begin
         s[4*c]   = m_tc[c] | m_ht[c] | m_te[c];
         s[4*c+1] = m_tc[c];
         s[4*c+2] = m_ht[c];
         s[4*c+3] = m_te[c];
      end
      return s;
   endfunction

   function automatic logic [N-1:0] exp_irq();
      return (m_tc & tc_en) | (m_ht & ht_en) | (m_te & te_en);
   endfunction

   task automatic check(string req, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // One clock: model follows the driven inputs, returns at the falling edge
   task automatic step();
      logic [31:0] cm;
      logic [N-1:0] ctc, cht, cte;
      cm = (bus_wr && bus_addr == 8'h04) ? bus_wdata : 32'h0;
      for (int c = 0; c < N; c++) begin
         ctc[c] = cm[4*c+1] | cm[4*c];
         cht[c] = cm[4*c+2] | cm[4*c];
         cte[c] = cm[4*c+3] | cm[4*c];
      end
      @(posedge clk);
      if (rst_n) begin
         m_tc = tc_evt | (m_tc & ~ctc);
         m_ht = ht_evt | (m_ht & ~cht);
         m_te = te_evt | (m_te & ~cte);
      end
      @(negedge clk);
   endtask

   task automatic idle();
      ht_evt = '0; tc_evt = '0; te_evt = '0;
      bus_wr = 1'b0; bus_addr = 8'h00; bus_wdata = '0;
   endtask

   task automatic read_status(string req, logic [31:0] lit);
      bus_addr = 8'h00; bus_wr = 1'b0;
      #1;
      check(req, bus_rdata, lit);
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired");
      finish_run();
   end

   initial begin
      void'($urandom(32'd20240611));
      repeat (3) @(posedge clk);
      @(negedge clk);
      // R1: reset state
      read_status("R1 status after reset", 32'h0);
      tc_en = '1; ht_en = '1; te_en = '1; #1;
      check("R1 irq after reset", 32'(irq), 32'h0);
      tc_en = '0; ht_en = '0; te_en = '0;
      rst_n = 1'b1;
      step();

      // R2: one-cycle pulse on channel 2 complete, sticky afterwards
      tc_evt[2] = 1'b1; step(); idle();
      step(); step();
      read_status("R2/R3 sticky complete flag ch2", 32'h0000_0300);

      // R7: enable selection
      te_en[2] = 1'b1; #1;
      check("R7 irq with non-matching enable", 32'(irq), 32'h0);
      te_en[2] = 1'b0; tc_en[2] = 1'b1; #1;
      check("R7 irq with matching enable", 32'(irq), 32'h04);

      // R4: clear only the complete flag, half flag stays
      ht_evt[2] = 1'b1; step(); idle();
      read_status("R2 half flag ch2", 32'h0000_0700);
      bus_wr = 1'b1; bus_addr = 8'h04; bus_wdata = 32'h0000_0200;
      step(); idle();
      read_status("R4 single clear", 32'h0000_0500);
      check("R7 irq after complete cleared", 32'(irq), 32'h0);

      // R10: interrupt timing around a clear
      ht_en[2] = 1'b1; #1;
      check("R10 irq before clear", 32'(irq), 32'h04);
      bus_wr = 1'b1; bus_addr = 8'h04; bus_wdata = 32'h0000_0400; #1;
      check("R10 irq held in clear cycle", 32'(irq), 32'h04);
      check("R8 clear word reads zero", bus_rdata, 32'h0);
      step(); idle(); #1;
      check("R10 irq low after clear", 32'(irq), 32'h0);
      ht_en = '0; tc_en = '0;

      // R5: group clear on channel 7, channel 0 untouched
      tc_evt[7] = 1'b1; ht_evt[7] = 1'b1; te_evt[7] = 1'b1; te_evt[0] = 1'b1;
      step(); idle();
      read_status("R2 all flags ch7", 32'hF000_0009);
      bus_wr = 1'b1; bus_addr = 8'h04; bus_wdata = 32'h1000_0000;
      step(); idle();
      read_status("R5 group clear ch7", 32'h0000_0009);

      // R6: event and clear of same flag in one cycle
      tc_evt[0] = 1'b1; bus_wr = 1'b1; bus_addr = 8'h04; bus_wdata = 32'h0000_000A;
      step(); idle();
      read_status("R6 event beats clear", 32'h0000_0003);

      // R9: write to the status offset
      bus_wr = 1'b1; bus_addr = 8'h00; bus_wdata = 32'hFFFF_FFFF;
      step(); idle();
      read_status("R9 status write ignored", 32'h0000_0003);

      // R8: unmapped address
      bus_addr = 8'h08; #1;
      check("R8 unmapped reads zero", bus_rdata, 32'h0);
      bus_addr = 8'h04; #1;
      check("R8 clear offset reads zero", bus_rdata, 32'h0);
      idle();

      // Random phase checked against the bench model
      for (int i = 0; i < 600; i++) begin
         bus_addr = 8'h00; bus_wr = 1'b0; #1;
         check("R2/R3/R4/R5/R6 random status", bus_rdata, exp_status());
         check("R7 random irq", 32'(irq), 32'(exp_irq()));
         tc_evt = N'($urandom & $urandom & $urandom);
         ht_evt = N'($urandom & $urandom & $urandom);
         te_evt = N'($urandom & $urandom & $urandom);
         tc_en = N'($urandom); ht_en = N'($urandom); te_en = N'($urandom);
         if ($urandom % 3 == 0) begin
            bus_wr = 1'b1; bus_addr = 8'h04; bus_wdata = $urandom & $urandom;
         end else if ($urandom % 6 == 0) begin
            bus_wr = 1'b1; bus_addr = ($urandom % 2 == 0) ? 8'h00 : 8'h0C;
            bus_wdata = $urandom;
         end
         #1;
         check("R10 random irq in write cycle", 32'(irq), 32'(exp_irq()));
         if (bus_addr == 8'h04)
            check("R8 random clear read", bus_rdata, 32'h0);
         step(); idle();
      end
      finish_run();
   end
endmodule